// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the interrupt bookkeeping of one processor's interrupt controller. It holds three vector sets of 256 bits each: the pending set, the in-service set and the trigger-mode set. Requests arrive one per cycle with a vector number and a level/edge flag. A software-visible task priority byte is written through its own port. From the task priority and the most urgent in-service vector, the block derives a processor priority. It then decides whether the best pending vector may interrupt the processor.

The processor takes an offered interrupt with a single-cycle acknowledge. The acknowledge returns the winning vector in the same cycle and moves it from pending to in service. An end-of-interrupt strobe retires the most urgent in-service vector. One cycle later the block reports which vector retired and whether it was level-triggered, so that an upstream source can re-arm. A global enable input suspends both the accepting of requests and delivery.

Top module: `vecprio_tracker`

## Requirements
- R1: Reset empties the pending, in-service and trigger sets and clears the task priority. After reset, ppr_out, tpr_out, int_pending and eoi_valid are all zero.
- R2: A task priority write stores only bits 7:0 of tpr_wdata, and tpr_out shows the stored byte from the next cycle on.
- R3: ppr_out equals the task priority when the task priority class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise ppr_out is that in-service class in bits 7:4 with bits 3:0 zero. An empty in-service set counts as class 0.
- R4: int_pending is high only when the block is enabled, the pending set is non-empty, and (highest pending vector & 0xF0) is strictly greater than ppr_out. While int_pending is high, int_vector is the highest pending vector.
- R5: A request is accepted when enabled, when its vector is 16 or above, and when its pending bit is clear. req_accepted is high in the same cycle. The vector's pending bit is set, and its trigger bit is written: 1 for level (req_level=1), 0 for edge.
- R6: A request whose vector is already pending, whether level or edge, is not accepted and changes no state.
- R7: While enable is low, requests are not accepted and leave the pending set unchanged, and int_pending is low.
- R8: ack_grant equals ack_req while int_pending is high. A grant moves int_vector from the pending set into the in-service set at the next clock edge.
- R9: An end-of-interrupt strobe when the in-service set is empty changes nothing, and eoi_valid stays low.
- R10: Otherwise an end-of-interrupt strobe clears the highest in-service bit and that vector's trigger bit. One cycle later eoi_valid pulses with eoi_vector set to that vector and eoi_level set to its trigger bit.
- R11: When a request, an acknowledge and an end-of-interrupt occur in the same cycle, they take effect in that order. The retire therefore sees the vector acknowledged in that cycle and the trigger bit written in that cycle.
- R12: Requests for vectors 0 to 15 are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global controller enable |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted | output | 1 | Request recorded this cycle |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data (bits 7:0 kept) |
| tpr_out | output | 8 | Stored task priority |
| ppr_out | output | 8 | Processor priority |
| int_pending | output | 1 | A pending vector may be delivered |
| int_vector | output | 8 | Vector offered for delivery |
| ack_req | input | 1 | Processor takes the offered interrupt |
| ack_grant | output | 1 | Acknowledge honoured this cycle |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_valid | output | 1 | A vector was retired in the previous cycle |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level-triggered |

## Verification
A lost or stray pending bit shows at once in int_pending and int_vector, or in req_accepted on the next request for that vector. A corrupted in-service bit shows in the same cycle as a wrong ppr_out, which also changes which requests are offered. It shows again one cycle after the next end-of-interrupt as a wrong eoi_vector. A wrong trigger bit stays hidden until its vector retires, and then appears only in eoi_level. For that reason the random stimulus keeps retiring vectors while requests of both kinds keep arriving.

// File: rtl/vecprio_pkg.sv
package vecprio_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // class comparison: vector class strictly above a priority byte
   function automatic logic class_above(input logic [3:0] cls, input logic [7:0] prio);
      return cls > prio[7:4];
   endfunction

endpackage

// File: rtl/vp_prio_enc.sv
module vp_prio_enc #(
   parameter int N       = 256,
   parameter int GROUP_W = 32
) (
   input  logic [N-1:0]         bits_i,
   output logic                 any_o,
   output logic [$clog2(N)-1:0] idx_o
);
   localparam int IDX_W = $clog2(N);

   initial begin
      assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("vp_prio_enc: N must be a power of two");
      assert (GROUP_W >= 2 && (GROUP_W & (GROUP_W - 1)) == 0)
         else $error("vp_prio_enc: GROUP_W must be a power of two");
   end

   generate
      if (GROUP_W >= N) begin : g_flat
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = 0; i < N; i++) begin
               if (bits_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end else begin : g_tree
         localparam int NG   = N / GROUP_W;
         localparam int GI_W = $clog2(GROUP_W);
         localparam int G_W  = $clog2(NG);

         logic [NG-1:0]   grp_any;
         logic [GI_W-1:0] grp_idx [NG];

         for (genvar g = 0; g < NG; g++) begin : g_grp
            logic            any_l;
            logic [GI_W-1:0] idx_l;
            always_comb begin
               any_l = 1'b0;
               idx_l = '0;
               for (int i = 0; i < GROUP_W; i++) begin
                  if (bits_i[g*GROUP_W + i]) begin
                     any_l = 1'b1;
                     idx_l = GI_W'(i);
                  end
               end
            end
            assign grp_any[g] = any_l;
            assign grp_idx[g] = idx_l;
         end

         always_comb begin
            any_o = |grp_any;
            idx_o = '0;
            for (int g = 0; g < NG; g++) begin
               if (grp_any[g]) idx_o = {G_W'(g), grp_idx[g]};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vp_prio_gate.sv
module vp_prio_gate #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4
) (
   input  logic             enable,
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_any,
   input  logic [VEC_W-1:0] isr_top,
   input  logic             irr_any,
   input  logic [VEC_W-1:0] irr_top,
   output logic [VEC_W-1:0] ppr,
   output logic             deliver
);
   localparam int SUB_W = VEC_W - CLS_W;

   initial begin
      assert (CLS_W >= 1 && CLS_W < VEC_W)
         else $error("vp_prio_gate: CLS_W out of range");
   end

   logic [CLS_W-1:0] isr_cls;
   logic [CLS_W-1:0] tpr_cls;
   logic [CLS_W-1:0] irr_cls;

   assign isr_cls = isr_any ? isr_top[VEC_W-1:SUB_W] : '0;
   assign tpr_cls = tpr[VEC_W-1:SUB_W];
   assign irr_cls = irr_top[VEC_W-1:SUB_W];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {SUB_W{1'b0}}};
   end

   // class strictly above the full priority byte
   assign deliver = enable && irr_any && (irr_cls > ppr[VEC_W-1:SUB_W]);

endmodule

// File: rtl/vp_vec_sets.sv
module vp_vec_sets #(
   parameter int VEC_W   = 8,
   parameter int MIN_VEC = 16,
   parameter int GROUP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   input  logic             req_level,
   output logic             req_ok,
   input  logic             ack_take,
   input  logic [VEC_W-1:0] ack_vec,
   input  logic             eoi,
   output logic [(1<<VEC_W)-1:0] irr_q,
   output logic [(1<<VEC_W)-1:0] isr_q,
   output logic             ret_valid_q,
   output logic [VEC_W-1:0] ret_vec_q,
   output logic             ret_level_q
);
   import vecprio_pkg::*;

   localparam int N = 1 << VEC_W;
   localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);

   initial begin
      assert (MIN_VEC >= 0 && MIN_VEC < N)
         else $error("vp_vec_sets: MIN_VEC out of range");
   end

   logic [N-1:0] tmr_q;
   logic [N-1:0] irr_d, isr_mid, isr_d, tmr_mid, tmr_d;
   logic         ret_any;
   logic [VEC_W-1:0] ret_idx;
   trig_e        req_mode;

   assign req_mode = req_level ? TRIG_LEVEL : TRIG_EDGE;
   assign req_ok   = req_valid && enable && (req_vec >= MIN_V) && !irr_q[req_vec];

   // stage 1: request, stage 2: acknowledge
   always_comb begin
      irr_d   = irr_q;
      tmr_mid = tmr_q;
      isr_mid = isr_q;
      if (req_ok) begin
         irr_d[req_vec]   = 1'b1;
         tmr_mid[req_vec] = (req_mode == TRIG_LEVEL);
      end
      if (ack_take) begin
         irr_d[ack_vec]   = 1'b0;
         isr_mid[ack_vec] = 1'b1;
      end
   end

   vp_prio_enc #(.N(N), .GROUP_W(GROUP_W)) u_ret_enc (
      .bits_i (isr_mid),
      .any_o  (ret_any),
      .idx_o  (ret_idx)
   );

   // stage 3: retire
   always_comb begin
      isr_d = isr_mid;
      tmr_d = tmr_mid;
      if (eoi && ret_any) begin
         isr_d[ret_idx] = 1'b0;
         tmr_d[ret_idx] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q       <= '0;
         isr_q       <= '0;
         tmr_q       <= '0;
         ret_valid_q <= 1'b0;
         ret_vec_q   <= '0;
         ret_level_q <= 1'b0;
      end else begin
         irr_q       <= irr_d;
         isr_q       <= isr_d;
         tmr_q       <= tmr_d;
         ret_valid_q <= eoi && ret_any;
         ret_vec_q   <= ret_idx;
         ret_level_q <= tmr_mid[ret_idx];
      end
   end

   // R6: a vector already pending is never accepted again
   a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && irr_q[req_vec]) |-> !req_ok);

   // R7: disabled controller leaves the pending set untouched
   a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(irr_q));

   // R8: granted vector lands in service and leaves pending
   a_r8_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && !eoi) |=> (isr_q[$past(ack_vec)] && !irr_q[$past(ack_vec)]));

   // R9: end-of-interrupt with nothing in service reports nothing
   a_r9_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack_take && (isr_q == '0)) |=> !ret_valid_q);

   // R10: a retire report only follows a strobe
   a_r10_report_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid_q |-> $past(eoi));

endmodule

// File: rtl/vecprio_tracker.sv
module vecprio_tracker #(
   parameter int VEC_W   = 8,
   parameter int CLS_W   = 4,
   parameter int MIN_VEC = 16,
   parameter int BUS_W   = 32,
   parameter int GROUP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vector,
   input  logic             req_level,
   output logic             req_accepted,
   input  logic             tpr_we,
   input  logic [BUS_W-1:0] tpr_wdata,
   output logic [VEC_W-1:0] tpr_out,
   output logic [VEC_W-1:0] ppr_out,
   output logic             int_pending,
   output logic [VEC_W-1:0] int_vector,
   input  logic             ack_req,
   output logic             ack_grant,
   input  logic             eoi,
   output logic             eoi_valid,
   output logic [VEC_W-1:0] eoi_vector,
   output logic             eoi_level
);
   localparam int N     = 1 << VEC_W;
   localparam int SUB_W = VEC_W - CLS_W;

   initial begin
      assert (BUS_W >= VEC_W) else $error("vecprio_tracker: BUS_W too small");
   end

   logic [VEC_W-1:0] tpr_q;
   logic [N-1:0]     irr_q, isr_q;
   logic             irr_any, isr_any, deliver;
   logic [VEC_W-1:0] irr_top, isr_top;

   always_ff @(posedge clk) begin
      if (!rst_n)      tpr_q <= '0;
      else if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
   end

   vp_prio_enc #(.N(N), .GROUP_W(GROUP_W)) u_irr_enc (
      .bits_i (irr_q),
      .any_o  (irr_any),
      .idx_o  (irr_top)
   );

   vp_prio_enc #(.N(N), .GROUP_W(GROUP_W)) u_isr_enc (
      .bits_i (isr_q),
      .any_o  (isr_any),
      .idx_o  (isr_top)
   );

   vp_prio_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
      .enable  (enable),
      .tpr     (tpr_q),
      .isr_any (isr_any),
      .isr_top (isr_top),
      .irr_any (irr_any),
      .irr_top (irr_top),
      .ppr     (ppr_out),
      .deliver (deliver)
   );

   assign int_pending = deliver;
   assign int_vector  = deliver ? irr_top : '0;
   assign ack_grant   = ack_req && deliver;
   assign tpr_out     = tpr_q;

   vp_vec_sets #(.VEC_W(VEC_W), .MIN_VEC(MIN_VEC), .GROUP_W(GROUP_W)) u_sets (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .req_valid   (req_valid),
      .req_vec     (req_vector),
      .req_level   (req_level),
      .req_ok      (req_accepted),
      .ack_take    (ack_grant),
      .ack_vec     (irr_top),
      .eoi         (eoi),
      .irr_q       (irr_q),
      .isr_q       (isr_q),
      .ret_valid_q (eoi_valid),
      .ret_vec_q   (eoi_vector),
      .ret_level_q (eoi_level)
   );

   // R2: only the low byte of a write is stored
   a_r2_tpr_write: assert property (@(posedge clk) disable iff (!rst_n)
      tpr_we |=> (tpr_q == $past(tpr_wdata[VEC_W-1:0])));

   // R3: processor priority class never drops below the task priority class
   a_r3_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_out[VEC_W-1:SUB_W] >= tpr_q[VEC_W-1:SUB_W]);

   // R4: an offered vector sits in a class above the processor priority
   a_r4_offer_above: assert property (@(posedge clk) disable iff (!rst_n)
      int_pending |-> (int_vector[VEC_W-1:SUB_W] > ppr_out[VEC_W-1:SUB_W]));

   // R7: no delivery while disabled
   a_r7_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !int_pending);

endmodule

// File: tb/vecprio_tracker_test.sv
`timescale 1ns/1ps
module vecprio_tracker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_level = 1'b0;
   logic        tpr_we = 1'b0;
   logic [31:0] tpr_wdata = '0;
   logic        ack_req = 1'b0;
   logic        eoi = 1'b0;
   logic        req_accepted, int_pending, ack_grant, eoi_valid, eoi_level;
   logic [7:0]  tpr_out, ppr_out, int_vector, eoi_vector;

   always #5 clk = ~clk;

   vecprio_tracker uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
      .req_accepted(req_accepted),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_out(tpr_out), .ppr_out(ppr_out),
      .int_pending(int_pending), .int_vector(int_vector),
      .ack_req(ack_req), .ack_grant(ack_grant),
      .eoi(eoi), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [255:0] m_irr, m_isr, m_tmr;
   logic [7:0]   m_tpr;
   logic         e_rv, e_rlvl;
   logic [7:0]   e_rvec;
   string        ret_tag = "";

   function automatic int top_bit(input logic [255:0] b);
      int r = -1;
      for (int i = 0; i < 256; i++) if (b[i]) r = i;
      return r;
   endfunction

   function automatic logic [7:0] calc_ppr(input logic [7:0] t, input logic [255:0] s);
      int h = top_bit(s);
      logic [3:0] c = (h < 0) ? 4'd0 : 4'(h >> 4);
      if (t[7:4] >= c) return t;
      return {c, 4'h0};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
      e_rv = 1'b0; e_rvec = '0; e_rlvl = 1'b0;
   endtask

   task automatic step(input bit rq, input int v, input bit lvl, input bit ak,
                       input bit eo, input bit en, input bit tw, input logic [31:0] td);
      int h, r;
      logic [7:0] p;
      bit pend, acc, g;
      string tg;
      @(negedge clk);
      tg = (ret_tag != "") ? ret_tag : (e_rv ? "R10" : "R9");
      chk(eoi_valid == e_rv, tg, "eoi_valid", eoi_valid, e_rv);
      if (e_rv) begin
         chk(eoi_vector == e_rvec, tg, "eoi_vector", eoi_vector, e_rvec);
         chk(eoi_level == e_rlvl, tg, "eoi_level", eoi_level, e_rlvl);
      end
      ret_tag = "";
      req_valid = rq; req_vector = 8'(v); req_level = lvl;
      ack_req = ak; eoi = eo; enable = en; tpr_we = tw; tpr_wdata = td;
      #1;
      h = top_bit(m_irr);
      p = calc_ppr(m_tpr, m_isr);
      pend = en && (h >= 0) && ((h & 'hF0) > int'(p));
      chk(ppr_out == p, "R3", "ppr_out", ppr_out, p);
      chk(tpr_out == m_tpr, "R2", "tpr_out", tpr_out, m_tpr);
      chk(int_pending == pend, en ? "R4" : "R7", "int_pending", int_pending, pend);
      if (pend) chk(int_vector == 8'(h), "R4", "int_vector", int_vector, h);
      acc = rq && en && (v >= 16) && !m_irr[v];
      if (!rq)          tg = "R5";
      else if (v < 16)  tg = "R12";
      else if (!en)     tg = "R7";
      else if (m_irr[v]) tg = "R6";
      else              tg = "R5";
      chk(req_accepted == acc, tg, "req_accepted", req_accepted, acc);
      g = ak && pend;
      chk(ack_grant == g, "R8", "ack_grant", ack_grant, g);
      // next state in request, acknowledge, retire order
      if (acc) begin m_irr[v] = 1'b1; m_tmr[v] = lvl; end
      if (g) begin m_irr[h] = 1'b0; m_isr[h] = 1'b1; end
      r = top_bit(m_isr);
      e_rv = eo && (r >= 0);
      if (e_rv) begin
         e_rvec = 8'(r);
         e_rlvl = m_tmr[r];
         m_isr[r] = 1'b0;
         m_tmr[r] = 1'b0;
      end
      if (tw) m_tpr = td[7:0];
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 0; ack_req = 0; eoi = 0; tpr_we = 0; enable = 1'b1;
      repeat (2) @(negedge clk);
      // R1: outputs while reset is held
      chk(int_pending == 1'b0, "R1", "int_pending", int_pending, 0);
      chk(ppr_out == 8'h00, "R1", "ppr_out", ppr_out, 0);
      chk(tpr_out == 8'h00, "R1", "tpr_out", tpr_out, 0);
      chk(eoi_valid == 1'b0, "R1", "eoi_valid", eoi_valid, 0);
      rst_n = 1'b1;
      model_clear();
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      do_reset();
      idle(1);

      // R2: upper write bits dropped
      step(0, 0, 0, 0, 0, 1, 1, 32'hABCD_123F);
      step(1, 'h45, 1, 0, 0, 1, 0, '0);           // R5 level request
      idle(1);                                      // R4: 0x40 > 0x3F offered
      step(0, 0, 0, 0, 0, 1, 1, 32'h0000_0040);
      idle(1);                                      // R4: 0x40 not above 0x40
      step(0, 0, 0, 0, 0, 1, 1, 32'h0000_0030);
      step(0, 0, 0, 1, 0, 1, 0, '0);               // R8 grant 0x45
      idle(1);                                      // R3: ppr from in-service class
      step(1, 'h45, 1, 0, 0, 1, 0, '0);            // R5 accepted again
      step(1, 'h45, 1, 0, 0, 1, 0, '0);            // R6 level repeat
      step(1, 'h45, 0, 0, 0, 1, 0, '0);            // R6 edge repeat
      step(1, 'h0F, 0, 0, 0, 1, 0, '0);            // R12
      step(1, 'h80, 0, 0, 0, 0, 0, '0);            // R7 disabled
      idle(1);
      step(0, 0, 0, 0, 1, 1, 0, '0);               // R10 retire 0x45
      idle(1);
      step(0, 0, 0, 0, 1, 1, 0, '0);               // R9 empty retire
      idle(1);
      // R11: request, acknowledge and retire together
      step(1, 'h60, 1, 0, 0, 1, 0, '0);
      step(1, 'h70, 0, 1, 1, 1, 0, '0);
      ret_tag = "R11";
      idle(1);
      chk(int_pending && int_vector == 8'h70, "R11", "int_vector", int_vector, 'h70);

      for (int i = 0; i < 4000; i++) begin
         int v;
         bit tw;
         v = ($urandom % 4 == 0) ? int'(8'h40 + ($urandom % 8) * 16 + 3) : int'($urandom % 256);
         tw = ($urandom % 20 == 0);
         step(($urandom % 2) == 1, v, ($urandom % 2) == 1, ($urandom % 2) == 1,
              ($urandom % 4) == 0, ($urandom % 20) != 0, tw,
              {$urandom, 8'h00} | 32'($urandom % 'h60));
      end

      // R1: reset mid-run empties every set
      step(1, 'h90, 1, 0, 0, 1, 1, 32'h10);
      do_reset();
      step(0, 0, 0, 0, 1, 1, 0, '0);
      idle(2);
      chk(int_pending == 1'b0, "R1", "int_pending after reset", int_pending, 0);

      done = 1'b1;
      finish_up();
   end

endmodule